// File: doc/BRIEF.md
# Boot Configuration and Protection Decoder

This block runs once after every reset. It reads a 16-bit protection word from a fixed location of the information memory over a request/ready port and keeps that word in a configuration register. Each protection and boot field is stored as three copies. The block resolves each field by a 2-of-3 vote. From the voted fields and two environment pins, it works out the start-up mode, the start address, and whether the CPU may leave reset at all.

After the word is latched, the block sits between three flash requesters and the flash array: the CPU, the debug port and an external programmer. It passes each access on or refuses it according to the voted read and write protection fields. A refused access returns zero data and raises a violation flag for one cycle.

Top module: `boot_prot_dec`

## Requirements
- R1: `info_addr` is always 0FEh. `info_req` is high from reset until the first cycle in which `info_ready` is high, and stays low after that.
- R2: Until the word has been latched, `config_valid` and `cpu_run` are low. After the latch, `config_valid` stays high and `cfg_word` holds the fetched word unchanged until the next reset.
- R3: The word is laid out as {wp[15:13], rp[12:10], isp[9:7], blank[6:4], bsz[3:1], 1}. Each 3-bit field counts as set when at least two of its bits are 1.
- R4: The boot area holds ~bsz blocks of 1024 bytes. The code-area start address is (~bsz)×400h, so bsz=111 gives 0000h and bsz=000 gives 1C00h.
- R5: The pins {env1,env0} are captured at the first clock edge after reset is released. Later changes on the pins have no effect on the mode or the start address.
- R6: With env=11 or 01, the outcome depends on the blank and isp votes:
  - blank set and isp set: ISP mode, starting at the code start.
  - blank clear and isp set: normal mode, starting at the code start.
  - isp clear: normal mode, starting at 0.
  - `start_mode` is encoded as 00 normal, 01 ISP and 10 DEV.
- R7: With env=10 (env1 high, env0 low), the block selects ISP mode at the code start, whatever the blank vote says.
- R8: With env=00, the block selects DEV mode at address 0, whatever the blank vote says.
- R9: In ISP mode with bsz=111, `cpu_run` stays low permanently.
- R10: Reads are selected by `acc_src` (0 CPU, 1 debug, 2 programmer, 3 treated as external). CPU reads are never blocked. External reads are granted only when both the rp vote and the wp vote are set.
- R11: When the wp vote is clear, writes from every source are blocked.
- R12: An access made before `config_valid`, or one that the protection refuses, drives `flash_en` low and `acc_rdata` to zero. `access_violation` then goes high in the following cycle, for one cycle per refused request. A granted read returns `flash_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| env0 | input | 1 | Environment pin 0 |
| env1 | input | 1 | Environment pin 1 |
| info_req | output | 1 | Information memory read request |
| info_addr | output | 8 | Information memory address (0FEh) |
| info_ready | input | 1 | Read data valid on the information port |
| info_rdata | input | 16 | Information memory read data |
| config_valid | output | 1 | Protection word latched |
| cfg_word | output | 16 | Latched protection word |
| start_mode | output | 2 | 00 normal, 01 ISP, 10 DEV |
| start_addr | output | 16 | CPU start address |
| cpu_run | output | 1 | CPU reset release |
| acc_valid | input | 1 | Flash access request |
| acc_src | input | 2 | Requester: 0 CPU, 1 debug, 2 programmer |
| acc_write | input | 1 | 1 write, 0 read |
| flash_rdata | input | 16 | Read data from flash |
| flash_en | output | 1 | Access passed on to flash |
| acc_rdata | output | 16 | Read data returned to requester |
| access_violation | output | 1 | One-cycle flag for a refused access |

## Verification
The bench aims at votes with exactly two bits set, where a decoder that used one bit or an AND of all three would pick the wrong mode. It also aims at bsz=111 under forced ISP and under an empty flash. Here a design that failed to hold the CPU would release `cpu_run`, and one that misread the inversion would report a boot area of 7 KB.

A read from the debug port is issued with only the write field cleared, which exposes a gate that looks at the read field alone. Accesses are issued while the fetch is still stalled, and the environment pins are changed after capture. These catch early grants and a mode that follows the live pins.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'b00,
    MODE_ISP    = 2'b01,
    MODE_DEV    = 2'b10
  } boot_mode_e;

  localparam logic [1:0] SRC_CPU = 2'd0;

  // Field positions inside the protection word (decoded by this block)
  localparam int WP_LSB    = 13;
  localparam int RP_LSB    = 10;
  localparam int ISP_LSB   = 7;
  localparam int BLANK_LSB = 4;
  localparam int BSZ_LSB   = 1;

  typedef struct packed {
    logic       wr_ok;
    logic       rd_ok;
    logic       isp_code;
    logic       blank;
    logic [2:0] blocks;
  } cfg_vote_t;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction
endpackage

// File: rtl/bpd_fetch.sv
module bpd_fetch #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              env0,
  input  logic              env1,
  output logic              info_req,
  input  logic              info_ready,
  input  logic [WORD_W-1:0] info_rdata,
  output logic              config_valid,
  output logic [WORD_W-1:0] cfg_word,
  output logic [1:0]        env_q
);
  logic              done_q, done_d;
  logic              envt_q, envt_d;
  logic              word_en, env_en;
  logic [WORD_W-1:0] word_q;
  logic [1:0]        envs_q;

  always_comb begin
    word_en = !done_q && info_ready;
    env_en  = !envt_q;
    done_d  = done_q | word_en;
    envt_d  = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      envt_q <= 1'b0;
    end else begin
      done_q <= done_d;
      envt_q <= envt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= info_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      envs_q <= 2'b00;
    end else if (env_en) begin
      envs_q <= {env1, env0};
    end
  end

  assign info_req     = !done_q;
  assign config_valid = done_q;
  assign cfg_word     = word_q;
  assign env_q        = envs_q;
endmodule

// File: rtl/bpd_decode.sv
module bpd_decode
  import bpd_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int BLOCK_BYTES = 1024
) (
  input  logic [15:1]       word,
  input  logic [1:0]        env_q,
  output cfg_vote_t         vote,
  output boot_mode_e        mode,
  output logic [ADDR_W-1:0] start_addr,
  output logic              hold
);
  localparam int BLK_SHIFT = $clog2(BLOCK_BYTES);

  logic [ADDR_W-1:0] code_start;
  logic              no_boot;

  always_comb begin
    vote.wr_ok    = maj3(word[WP_LSB+:3]);
    vote.rd_ok    = maj3(word[RP_LSB+:3]);
    vote.isp_code = maj3(word[ISP_LSB+:3]);
    vote.blank    = maj3(word[BLANK_LSB+:3]);
    vote.blocks   = ~word[BSZ_LSB+:3];
    no_boot       = (vote.blocks == 3'd0);
    code_start    = ADDR_W'(vote.blocks) << BLK_SHIFT;
  end

  always_comb begin
    mode       = MODE_NORMAL;
    start_addr = '0;
    case (env_q)
      2'b00: begin
        mode       = MODE_DEV;
        start_addr = '0;
      end
      2'b10: begin
        mode       = MODE_ISP;
        start_addr = code_start;
      end
      default: begin
        if (vote.isp_code) begin
          mode       = vote.blank ? MODE_ISP : MODE_NORMAL;
          start_addr = code_start;
        end
      end
    endcase
    hold = (mode == MODE_ISP) && no_boot;
  end
endmodule

// File: rtl/bpd_gate.sv
module bpd_gate
  import bpd_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              config_valid,
  input  logic              rd_ok,
  input  logic              wr_ok,
  input  logic              acc_valid,
  input  logic [1:0]        acc_src,
  input  logic              acc_write,
  input  logic [DATA_W-1:0] flash_rdata,
  output logic              flash_en,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              access_violation
);
  logic allowed;
  logic viol_d, viol_q;

  always_comb begin
    if (!config_valid) begin
      allowed = 1'b0;
    end else if (acc_write) begin
      allowed = wr_ok;
    end else begin
      allowed = (acc_src == SRC_CPU) || (rd_ok && wr_ok);
    end
    flash_en  = acc_valid && allowed;
    acc_rdata = (flash_en && !acc_write) ? flash_rdata : '0;
    viol_d    = acc_valid && !allowed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_q <= 1'b0;
    end else begin
      viol_q <= viol_d;
    end
  end

  assign access_violation = viol_q;
endmodule

// File: rtl/boot_prot_dec.sv
module boot_prot_dec
  import bpd_pkg::*;
#(
  parameter int          INFO_AW     = 8,
  parameter logic [7:0]  PROT_ADDR   = 8'hFE,
  parameter int          ADDR_W      = 16,
  parameter int          DATA_W      = 16,
  parameter int          BLOCK_BYTES = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               env0,
  input  logic               env1,
  output logic               info_req,
  output logic [INFO_AW-1:0] info_addr,
  input  logic               info_ready,
  input  logic [15:0]        info_rdata,
  output logic               config_valid,
  output logic [15:0]        cfg_word,
  output logic [1:0]         start_mode,
  output logic [ADDR_W-1:0]  start_addr,
  output logic               cpu_run,
  input  logic               acc_valid,
  input  logic [1:0]         acc_src,
  input  logic               acc_write,
  input  logic [DATA_W-1:0]  flash_rdata,
  output logic               flash_en,
  output logic [DATA_W-1:0]  acc_rdata,
  output logic               access_violation
);
  logic [1:0] env_q;
  cfg_vote_t  vote;
  boot_mode_e mode;
  logic       hold;

  bpd_fetch #(.WORD_W(16)) u_fetch (
    .clk(clk), .rst_n(rst_n), .env0(env0), .env1(env1),
    .info_req(info_req), .info_ready(info_ready), .info_rdata(info_rdata),
    .config_valid(config_valid), .cfg_word(cfg_word), .env_q(env_q)
  );

  bpd_decode #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BLOCK_BYTES)) u_dec (
    .word(cfg_word[15:1]), .env_q(env_q), .vote(vote), .mode(mode),
    .start_addr(start_addr), .hold(hold)
  );

  bpd_gate #(.DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .config_valid(config_valid),
    .rd_ok(vote.rd_ok), .wr_ok(vote.wr_ok), .acc_valid(acc_valid),
    .acc_src(acc_src), .acc_write(acc_write), .flash_rdata(flash_rdata),
    .flash_en(flash_en), .acc_rdata(acc_rdata),
    .access_violation(access_violation)
  );

  assign info_addr  = INFO_AW'(PROT_ADDR);
  assign start_mode = mode;
  assign cpu_run    = config_valid && !hold;
endmodule

// File: rtl/bpd_chk.sv
module bpd_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        info_req,
  input logic        config_valid,
  input logic [15:0] cfg_word,
  input logic [1:0]  start_mode,
  input logic        cpu_run,
  input logic        acc_valid,
  input logic [1:0]  acc_src,
  input logic        acc_write,
  input logic        flash_en,
  input logic        access_violation
);
  a_r1_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
    config_valid |-> !info_req);

  a_r2_hold_until_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !config_valid |-> !cpu_run);

  a_r2_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
    config_valid |=> (config_valid && $stable(cfg_word)));

  a_r9_noboot_isp_held: assert property (@(posedge clk) disable iff (!rst_n)
    (config_valid && start_mode == 2'b01 && cfg_word[3:1] == 3'b111) |-> !cpu_run);

  a_r10_cpu_read_open: assert property (@(posedge clk) disable iff (!rst_n)
    (config_valid && acc_valid && !acc_write && acc_src == 2'd0) |-> flash_en);

  a_r11_no_blocked_write: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_en && acc_write) |-> ($countones(cfg_word[15:13]) >= 2));

  a_r12_violation_cause: assert property (@(posedge clk) disable iff (!rst_n)
    access_violation |-> $past(acc_valid && !flash_en));
endmodule

bind boot_prot_dec bpd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .info_req(info_req), .config_valid(config_valid),
  .cfg_word(cfg_word), .start_mode(start_mode), .cpu_run(cpu_run),
  .acc_valid(acc_valid), .acc_src(acc_src), .acc_write(acc_write),
  .flash_en(flash_en), .access_violation(access_violation)
);

// File: tb/sim_boot_prot_dec.sv
module sim_boot_prot_dec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        env0 = 1'b1, env1 = 1'b1;
  logic        info_req;
  logic [7:0]  info_addr;
  logic        info_ready = 1'b0;
  logic [15:0] info_rdata = 16'h0;
  logic        config_valid;
  logic [15:0] cfg_word;
  logic [1:0]  start_mode;
  logic [15:0] start_addr;
  logic        cpu_run;
  logic        acc_valid = 1'b0;
  logic [1:0]  acc_src = 2'd0;
  logic        acc_write = 1'b0;
  logic [15:0] flash_rdata = 16'hA5C3;
  logic        flash_en;
  logic [15:0] acc_rdata;
  logic        access_violation;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // behavioural reference state
  bit          m_valid, m_envt, m_viol;
  logic [15:0] m_word;
  logic [1:0]  m_env;
  string       m_tag = "R6";

  always #5 clk = ~clk;

  boot_prot_dec u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit vote(input logic [2:0] f);
    int n = 0;
    for (int i = 0; i < 3; i++) if (f[i]) n++;
    return n >= 2;
  endfunction

  function automatic int exp_code(input logic [15:0] w);
    return (7 - int'(w[3:1])) * 1024;
  endfunction

  // returns mode*65536 + start address; hold returned separately
  function automatic int exp_boot(input logic [15:0] w, input logic [1:0] e, output bit hold);
    int mode, addr;
    if (e == 2'b00) begin mode = 2; addr = 0; end
    else if (e == 2'b10) begin mode = 1; addr = exp_code(w); end
    else if (vote(w[9:7]) && vote(w[6:4])) begin mode = 1; addr = exp_code(w); end
    else if (vote(w[9:7])) begin mode = 0; addr = exp_code(w); end
    else begin mode = 0; addr = 0; end
    hold = (mode == 1) && (w[3:1] == 3'b111);
    return mode * 65536 + addr;
  endfunction

  function automatic bit exp_allow(input bit valid, input logic [15:0] w,
                                   input logic [1:0] src, input bit wr);
    if (!valid) return 0;
    if (wr) return vote(w[15:13]);
    if (src == 2'd0) return 1;
    return vote(w[12:10]) && vote(w[15:13]);
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      cycles++;
      m_viol = acc_valid && !exp_allow(m_valid, m_word, acc_src, acc_write);
      if (!m_envt) begin m_env = {env1, env0}; m_envt = 1; end
      if (!m_valid && info_ready) begin m_valid = 1; m_word = info_rdata; end
    end
    #3;
    begin
      bit hold, al;
      int eb;
      chk(info_addr == 8'hFE, "R1 info_addr", info_addr, 8'hFE);
      chk(info_req == !m_valid, "R1 info_req", info_req, !m_valid);
      chk(config_valid == m_valid, "R2 config_valid", config_valid, m_valid);
      al = acc_valid && exp_allow(m_valid, m_word, acc_src, acc_write);
      chk(flash_en == al, acc_write ? "R11 flash_en" : "R10 flash_en", flash_en, al);
      chk(acc_rdata == ((al && !acc_write) ? flash_rdata : 16'h0), "R12 acc_rdata",
          acc_rdata, (al && !acc_write) ? flash_rdata : 16'h0);
      chk(access_violation == (rst_n && m_viol), "R12 violation", access_violation,
          rst_n && m_viol);
      if (m_valid) begin
        eb = exp_boot(m_word, m_env, hold);
        chk(cfg_word == m_word, "R2 cfg_word", cfg_word, m_word);
        chk(int'(start_mode) == eb / 65536, m_tag, start_mode, eb / 65536);
        chk(int'(start_addr) == eb % 65536, "R4 start_addr", start_addr, eb % 65536);
        chk(cpu_run == !hold, "R9 cpu_run", cpu_run, !hold);
      end else begin
        chk(cpu_run == 1'b0, "R2 cpu_run", cpu_run, 0);
      end
    end
  end

  always @(posedge clk) begin
    if (cycles >= 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic boot(input logic [15:0] w, input logic e1, input logic e0,
                      input int stall, input string tag);
    @(negedge clk);
    rst_n = 0; info_ready = 0; acc_valid = 0;
    env1 = e1; env0 = e0; m_tag = tag;
    m_valid = 0; m_envt = 0; m_viol = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    // accesses while the fetch is stalled must be refused (R12)
    for (int i = 0; i < stall; i++) begin
      acc_valid = (i % 2 == 0); acc_src = 2'd0; acc_write = 1'b0;
      @(negedge clk);
    end
    acc_valid = 0;
    info_rdata = w; info_ready = 1;
    @(negedge clk);
    info_ready = 0; info_rdata = ~w;
    // R5: later pin changes must not move the mode
    env1 = ~e1; env0 = ~e0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sweep();
    for (int s = 0; s < 3; s++) begin
      for (int wr = 0; wr < 2; wr++) begin
        acc_valid = 1; acc_src = 2'(s); acc_write = wr[0];
        flash_rdata = 16'h1000 + 16'(s * 16 + wr);
        @(negedge clk);
      end
    end
    acc_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [15:0] mk(input logic [2:0] wp, rp, isp, blank, bsz);
    return {wp, rp, isp, blank, bsz, 1'b1};
  endfunction

  initial begin
    // R6: programmed, boot routines present -> normal at code start 0800h
    boot(mk(3'b111, 3'b111, 3'b111, 3'b000, 3'b101), 1, 1, 3, "R6 mode programmed");
    sweep();
    // R3: two-of-three votes: isp 011, blank 110 -> ISP at 1400h
    boot(mk(3'b101, 3'b110, 3'b011, 3'b110, 3'b010), 1, 1, 0, "R3 mode vote");
    sweep();
    // R6: empty but isp clear (001) -> normal at 0
    boot(mk(3'b111, 3'b111, 3'b001, 3'b111, 3'b100), 1, 1, 1, "R6 mode no isp");
    // R7: forced ISP, programmed flash, bsz 000 -> 1C00h
    boot(mk(3'b111, 3'b111, 3'b000, 3'b000, 3'b000), 1, 0, 2, "R7 mode forced");
    // R9: forced ISP with no boot area -> held
    boot(mk(3'b111, 3'b111, 3'b000, 3'b000, 3'b111), 1, 0, 0, "R9 mode forced noboot");
    // R8: DEV ignores blank
    boot(mk(3'b111, 3'b111, 3'b111, 3'b111, 3'b110), 0, 0, 0, "R8 mode dev");
    // R9: empty, isp, no boot area -> held
    boot(mk(3'b111, 3'b111, 3'b111, 3'b111, 3'b111), 1, 1, 0, "R9 mode empty noboot");
    // R5: env 01 behaves as auto, pins flip after capture
    boot(mk(3'b111, 3'b111, 3'b110, 3'b000, 3'b011), 0, 1, 0, "R5 mode env capture");
    // R10: read field clear -> external reads refused, cpu reads granted
    boot(mk(3'b111, 3'b100, 3'b000, 3'b000, 3'b111), 1, 1, 0, "R6 mode gating rd");
    sweep();
    // R11: write field clear (010) -> all writes and external reads refused
    boot(mk(3'b010, 3'b111, 3'b000, 3'b000, 3'b111), 1, 1, 2, "R6 mode gating wr");
    sweep();
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule